// File: doc/BRIEF.md
# Single-Byte SPI Master with Movable Input Sample Point

This block is an SPI bus master that moves one byte per start request. The host sets up the transfer on plain input pins: a clock polarity bit, a clock phase bit, a sample-timing bit and a chip-select polarity bit. It also supplies a half-period divider and the byte to send, then pulses `start`. When all bits have been exchanged, the block presents the received byte and raises `done` for one system clock.

The clock polarity and phase bits give the four usual SPI modes. The sample-timing bit works on its own, separate from those two. Each data bit occupies a window of one full serial clock period that opens when the bit is launched. With the bit clear, `spi_miso` is captured in the middle of that window. This is the conventional edge, so no long hold time is asked of the slave. With the bit set, the capture moves to the end of the window.

A transfer is a fixed run of 2·DATA_W+2 half-periods. The first half-period is the chip-select lead time and the last half-period is the guard time. Every setting is latched at the start strobe. While no transfer is running, the idle pin levels follow the live configuration inputs.

Top module: `spi_sample_master`

## Requirements
- R1: After synchronous reset, `done` is 0, `rx_byte` is 0 and `spi_mosi` is 0. While idle, `spi_sclk` equals `mode_cpol` and `spi_cs` equals the inverse of `mode_cs_high`.
- R2: After the edge that accepts `start`, `spi_cs` stays at its active level for exactly 2·DATA_W+2 half-periods. It returns to inactive on the edge that raises `done`.
- R3: Number the half-periods of a transfer as slots 0 to 2·DATA_W+1. `spi_sclk` is the inverse of the latched polarity in the odd slots 1 to 2·DATA_W−1, and equals the latched polarity in every other slot.
- R4: Data leaves on `spi_mosi` MSB first. Bit i (0 = MSB) is driven from slot 2i+cpha onward. Before its first bit the line shows the MSB, after its last bit it holds the LSB, and it is 0 while idle.
- R5: Bit i of the received byte is the `spi_miso` level at the end of slot 2i+cpha when the sample-timing bit is 0, and at the end of slot 2i+cpha+1 when it is 1. Exactly DATA_W captures occur per transfer.
- R6: A half-period lasts `half_div` system clocks, and a value of 0 counts as 1.
- R7: `done` is high for exactly one cycle, (2·DATA_W+2)·H clocks after the accepting edge, where H is the half-period length. `rx_byte` changes only on that edge.
- R8: Changes to the mode bits, `half_div`, `tx_byte` or `start` during a transfer have no effect on the byte in flight.
- R9: `mode_cs_high` = 1 makes the active chip-select level high. With 0 the active level is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transfer when idle |
| tx_byte | input | DATA_W | Byte to send |
| half_div | input | DIV_W | Serial clock half-period in system clocks (0 treated as 1) |
| mode_cpol | input | 1 | Serial clock idle level |
| mode_cpha | input | 1 | 0: launch before leading edge; 1: launch on leading edge |
| mode_late | input | 1 | 0: sample mid-window; 1: sample at end of window |
| mode_cs_high | input | 1 | Chip-select active level |
| rx_byte | output | DATA_W | Last received byte |
| done | output | 1 | One-cycle completion pulse |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs | output | 1 | Chip select |

## Verification
The bench builds the block with DATA_W = 8 and DIV_W = 4. It sweeps half-periods of 0, 1, 2, 3 and 5 clocks. With the divider at 0 and at 1, every system clock is a slot boundary, so the first and last slots are one clock wide and each launch, capture and finish decision must land on its own edge. The bench drives `spi_miso` with a new level in every slot. Capturing mid-window or at end of window therefore gives different bytes in all eight combinations of polarity, phase and sample timing. The 4-bit divider also lets mid-transfer scrambling push the divider to its maximum without any effect on the byte in flight.

// File: rtl/spim_pkg.sv
`timescale 1ns/1ps
package spim_pkg;

    typedef struct packed {
        logic cpol;
        logic cpha;
        logic late;
        logic cs_hi;
    } spim_mode_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } spim_state_e;

    // slot boundary j at which bit i is captured: j = 2i + cpha + 1 + late
    function automatic logic is_sample_pt(int j, logic cpha, logic late, int w);
        int d;
        d = j - 1 - int'(cpha) - int'(late);
        return (d >= 0) && (d[0] == 1'b0) && (d <= 2 * w - 2);
    endfunction

    // slot boundary j at which bit i (i >= 1) is launched: j = 2i + cpha
    function automatic logic is_launch_pt(int j, logic cpha, int w);
        int e;
        e = j - int'(cpha);
        return (e >= 2) && (e[0] == 1'b0) && (e <= 2 * w - 2);
    endfunction

    // serial clock sits at its active level in odd slots up to 2w-1
    function automatic logic sclk_on(int slot, int w);
        return (slot[0] == 1'b1) && (slot <= 2 * w - 1);
    endfunction

endpackage

// File: rtl/spim_halfper.sv
`timescale 1ns/1ps
module spim_halfper #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             run,
    input  logic [DIV_W-1:0] half,
    output logic             tick
);
    localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

    logic [DIV_W-1:0] cnt;

    assign tick = run && (cnt == half - ONE);

    always_ff @(posedge clk) begin
        if (rst || clear || tick) begin
            cnt <= '0;
        end else if (run) begin
            cnt <= cnt + ONE;
        end
    end

    AST_CNT_BELOW_HALF: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt < half)) else $error("half-period counter overran"); // R6

endmodule

// File: rtl/spim_seq.sv
`timescale 1ns/1ps
module spim_seq
    import spim_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 8,
    localparam int LAST_SLOT = 2 * DATA_W + 1,
    localparam int SLOT_W    = $clog2(LAST_SLOT + 2)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  spim_mode_t        mode_in,
    input  logic [DIV_W-1:0]  div_in,
    input  logic              tick,
    output logic              running,
    output logic [SLOT_W-1:0] slot,
    output spim_mode_t        mode_q,
    output logic [DIV_W-1:0]  half_q,
    output logic              load,
    output logic              shift_tx,
    output logic              sample,
    output logic              finish
);
    localparam logic [SLOT_W-1:0] LAST_V = SLOT_W'(LAST_SLOT);
    localparam logic [DIV_W-1:0]  ONE    = DIV_W'(1);

    spim_state_e state;
    int          bnd;

    assign running = (state == ST_RUN);
    assign load    = start && (state == ST_IDLE);

    always_comb begin
        bnd      = int'(slot) + 1;
        shift_tx = tick && is_launch_pt(bnd, mode_q.cpha, DATA_W);
        sample   = tick && is_sample_pt(bnd, mode_q.cpha, mode_q.late, DATA_W);
        finish   = tick && (slot == LAST_V);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            slot   <= '0;
            mode_q <= '0;
            half_q <= ONE;
        end else if (load) begin
            state  <= ST_RUN;
            slot   <= '0;
            mode_q <= mode_in;
            half_q <= (div_in == '0) ? ONE : div_in;
        end else if (tick) begin
            if (finish) begin
                state <= ST_IDLE;
            end else begin
                slot <= slot + SLOT_W'(1);
            end
        end
    end

    AST_SLOT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        running |-> (slot <= LAST_V)) else $error("slot beyond frame"); // R2

    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (running && start && !finish) |=> (running && $stable(mode_q) && $stable(half_q)))
        else $error("start accepted mid transfer"); // R8

    AST_NO_SAMPLE_AT_LAUNCH: assert property (@(posedge clk) disable iff (rst)
        shift_tx |-> !finish) else $error("launch on final boundary"); // R4

endmodule

// File: rtl/spim_shifter.sv
`timescale 1ns/1ps
module spim_shifter #(
    parameter int DATA_W = 8,
    localparam int SCNT_W = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] tx_in,
    input  logic              shift_tx,
    input  logic              sample,
    input  logic              miso,
    input  logic              finish,
    output logic              tx_msb,
    output logic [DATA_W-1:0] rx_q,
    output logic              done_q
);
    logic [DATA_W-1:0] tx_sh;
    logic [DATA_W-1:0] rx_sh;
    logic [SCNT_W-1:0] n_cap;

    assign tx_msb = tx_sh[DATA_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_sh <= '0;
            rx_sh <= '0;
        end else begin
            if (load) begin
                tx_sh <= tx_in;
            end else if (shift_tx) begin
                tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
            end
            if (sample) begin
                rx_sh <= {rx_sh[DATA_W-2:0], miso};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_q   <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= finish;
            if (finish) begin
                rx_q <= rx_sh;
            end
        end
    end

    // capture tally, used only by the checks below
    always_ff @(posedge clk) begin
        if (rst || load) begin
            n_cap <= '0;
        end else if (sample) begin
            n_cap <= n_cap + SCNT_W'(1);
        end
    end

    AST_FULL_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        finish |-> (n_cap == SCNT_W'(DATA_W))) else $error("capture count wrong"); // R5

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q) else $error("done wider than one cycle"); // R7

    AST_RX_HELD: assert property (@(posedge clk) disable iff (rst)
        !finish |=> $stable(rx_q)) else $error("rx_byte moved outside finish"); // R7

endmodule

// File: rtl/spi_sample_master.sv
`timescale 1ns/1ps
module spi_sample_master
    import spim_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [DATA_W-1:0] tx_byte,
    input  logic [DIV_W-1:0]  half_div,
    input  logic              mode_cpol,
    input  logic              mode_cpha,
    input  logic              mode_late,
    input  logic              mode_cs_high,
    output logic [DATA_W-1:0] rx_byte,
    output logic              done,
    output logic              spi_sclk,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic              spi_cs
);
    localparam int SLOT_W = $clog2(2 * DATA_W + 3);

    spim_mode_t        live_mode;
    spim_mode_t        mode_q;
    logic              running;
    logic [SLOT_W-1:0] slot;
    logic [DIV_W-1:0]  half_q;
    logic              tick;
    logic              load;
    logic              shift_tx;
    logic              sample;
    logic              finish;
    logic              tx_msb;

    assign live_mode = '{cpol: mode_cpol, cpha: mode_cpha,
                         late: mode_late, cs_hi: mode_cs_high};

    spim_seq #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_seq (
        .clk(clk), .rst(rst), .start(start), .mode_in(live_mode),
        .div_in(half_div), .tick(tick), .running(running), .slot(slot),
        .mode_q(mode_q), .half_q(half_q), .load(load), .shift_tx(shift_tx),
        .sample(sample), .finish(finish)
    );

    spim_halfper #(.DIV_W(DIV_W)) u_half (
        .clk(clk), .rst(rst), .clear(load), .run(running),
        .half(half_q), .tick(tick)
    );

    spim_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk(clk), .rst(rst), .load(load), .tx_in(tx_byte),
        .shift_tx(shift_tx), .sample(sample), .miso(spi_miso),
        .finish(finish), .tx_msb(tx_msb), .rx_q(rx_byte), .done_q(done)
    );

    always_comb begin
        if (running) begin
            spi_cs   = mode_q.cs_hi;
            spi_sclk = mode_q.cpol ^ sclk_on(int'(slot), DATA_W);
            spi_mosi = tx_msb;
        end else begin
            spi_cs   = !live_mode.cs_hi;
            spi_sclk = live_mode.cpol;
            spi_mosi = 1'b0;
        end
    end

    AST_CS_HELD_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
        (running && $past(running)) |-> $stable(spi_cs)) else $error("cs moved in frame"); // R2

    AST_CS_OFF_AT_DONE: assert property (@(posedge clk) disable iff (rst)
        done |-> (spi_cs == !mode_cs_high)) else $error("cs active at done"); // R9

    AST_SCLK_QUIET_GUARDS: assert property (@(posedge clk) disable iff (rst)
        (running && (slot == '0 || slot >= SLOT_W'(2 * DATA_W))) |-> (spi_sclk == mode_q.cpol))
        else $error("sclk active in lead or guard slot"); // R3

endmodule

// File: tb/tb_spi_sample_master.sv
`timescale 1ns/1ps
module tb_spi_sample_master;

    localparam int W     = 8;
    localparam int DW    = 4;
    localparam int NSLOT = 2 * W + 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [W-1:0]  tx_byte = '0;
    logic [DW-1:0] half_div = '0;
    logic          cpol = 1'b0, cpha = 1'b0, late = 1'b0, cs_high = 1'b0;
    logic [W-1:0]  rx_byte;
    logic          done, sclk, mosi, cs;
    logic          miso = 1'b0;

    always #2 clk = ~clk;

    spi_sample_master #(.DATA_W(W), .DIV_W(DW)) dut (
        .clk(clk), .rst(rst), .start(start), .tx_byte(tx_byte),
        .half_div(half_div), .mode_cpol(cpol), .mode_cpha(cpha),
        .mode_late(late), .mode_cs_high(cs_high), .rx_byte(rx_byte),
        .done(done), .spi_sclk(sclk), .spi_mosi(mosi), .spi_miso(miso),
        .spi_cs(cs)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    string ctx = "";

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural reference model
    bit             m_run = 0, m_done = 0;
    int             k = 0, hp = 1;
    logic           m_cpol, m_cpha, m_cshi;
    logic [W-1:0]   m_tx, m_rx, pend_rx;
    logic [NSLOT-1:0] m_pat, cur_pat = '0;

    always @(posedge clk) begin
        if (rst) begin
            m_run = 0; m_done = 0; m_rx = '0; k = 0;
        end else begin
            m_done = 0;
            if (m_run) begin
                k++;
                if (k == NSLOT * hp) begin
                    m_run = 0; m_done = 1; m_rx = pend_rx;
                end
            end else if (start) begin
                m_run = 1; k = 0;
                hp = (half_div == 0) ? 1 : int'(half_div);
                m_cpol = cpol; m_cpha = cpha; m_cshi = cs_high;
                m_tx = tx_byte; m_pat = cur_pat;
                for (int i = 0; i < W; i++) begin
                    pend_rx[W-1-i] = cur_pat[2*i + int'(cpha) + int'(late)];
                end
            end
        end
    end

    // compare every cycle, away from the active edge; drive the slave line
    always @(negedge clk) begin
        #1;
        if (!rst) begin
            logic e_cs, e_sclk, e_mosi;
            int sl, b;
            if (m_run) begin
                sl = k / hp;
                e_cs = m_cshi;
                e_sclk = m_cpol ^ ((sl % 2 == 1) && (sl <= 2 * W - 1));
                b = sl - int'(m_cpha);
                if (b < 0) b = 0;
                b = b / 2;
                if (b > W - 1) b = W - 1;
                e_mosi = m_tx[W-1-b];
                miso = m_pat[sl];
            end else begin
                e_cs = !cs_high; e_sclk = cpol; e_mosi = 1'b0;
                miso = 1'b0;
            end
            chk(cs == e_cs, {"R2 R9 cs", ctx}, cs, e_cs);
            chk(sclk == e_sclk, {"R3 R6 sclk", ctx}, sclk, e_sclk);
            chk(mosi == e_mosi, {"R4 mosi", ctx}, mosi, e_mosi);
            chk(done == m_done, {"R7 done", ctx}, done, m_done);
            chk(rx_byte == m_rx, {"R5 rx_byte", ctx}, rx_byte, m_rx);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            chk(1'b0, "R7 watchdog", cyc, 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    // called at a negedge; returns at the negedge following the finish edge
    task automatic xfer(input logic p, input logic h, input logic lt, input logic csh,
                        input logic [DW-1:0] dv, input logic [W-1:0] tx,
                        input logic [NSLOT-1:0] pat, input bit scramble);
        cpol = p; cpha = h; late = lt; cs_high = csh;
        half_div = dv; tx_byte = tx; cur_pat = pat; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (scramble) ctx = " R8";
        while (m_run) begin
            if (scramble) begin
                cpol = ~cpol; cpha = ~cpha; late = ~late; cs_high = ~cs_high;
                half_div = half_div + DW'(7); tx_byte = ~tx_byte;
                start = ~start;
            end
            @(negedge clk);
        end
        start = 1'b0;
        ctx = "";
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk(cs == 1'b1, "R1 reset cs", cs, 1);
        chk(sclk == 1'b0, "R1 reset sclk", sclk, 0);
        chk(mosi == 1'b0, "R1 reset mosi", mosi, 0);
        chk(done == 1'b0, "R1 reset done", done, 0);
        chk(rx_byte == '0, "R1 reset rx", rx_byte, 0);
        @(negedge clk);
        cpol = 1'b1; cs_high = 1'b1;
        #1;
        chk(sclk == 1'b1, "R1 idle sclk follows polarity", sclk, 1);
        chk(cs == 1'b0, "R1 R9 idle cs inactive low", cs, 0);
        @(negedge clk);

        // all eight polarity/phase/sample combinations, several dividers
        for (int idx = 0; idx < 8; idx++) begin
            xfer(idx[2], idx[1], idx[0], idx[0] ^ idx[2], DW'(idx % 4),
                 W'(8'hA5 ^ (idx * 37)), NSLOT'(18'h2AAAA ^ (idx * 18'h0913)), 0);
        end
        // alternating slave pattern separates mid from late capture
        xfer(0, 0, 0, 0, 3, 8'h3C, 18'h15555, 0);
        xfer(0, 0, 1, 0, 3, 8'h3C, 18'h15555, 0);
        xfer(1, 1, 0, 1, 1, 8'h81, 18'h2AAAA, 0);
        xfer(1, 1, 1, 1, 1, 8'h81, 18'h2AAAA, 0);
        repeat (4) @(negedge clk);
        // divider 0 behaves as 1, and the largest divider used
        xfer(0, 1, 1, 0, 0, 8'hFF, 18'h0F0F3, 0);
        xfer(1, 0, 0, 0, 5, 8'h00, 18'h3FFC0, 0);
        // settings and start toggled while a byte is in flight
        xfer(0, 0, 0, 0, 5, 8'hC3, 18'h1B6D9, 1);
        repeat (3) @(negedge clk);
        xfer(1, 1, 1, 1, 2, 8'h5A, 18'h24924, 1);
        repeat (3) @(negedge clk);
        xfer(0, 1, 0, 1, 2, 8'h96, 18'h31C71, 0);
        repeat (5) @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule